// File: doc/BRIEF.md
# Trap Context Save and Restore Sequencer

This block is the multi-cycle engine a 16-bit processor calls on when an instruction must be handed to a software handler, and again when that handler is finished. On an entry command it fetches a system stack address from a memory-resident vector. It then pushes the processor context onto that stack as a fixed 10-byte frame, one byte per cycle, and reads the handler address from a second vector. On a return command it walks the same frame upward from the current stack pointer and rebuilds the accumulator, the index register, the program counter, the condition flags and the stack pointer.

The processor presents the instruction-specifier byte, the stack pointer, the program counter, the index register, the accumulator and the 4-bit condition flags when it raises `start`. The bit `startKind` selects entry (0) or return (1). Memory is reached through a byte-wide port with an asynchronous read: the byte at `memAddr` appears on `memRdata` in the same cycle. When the work is over, the new register values are presented together with a one-cycle `done` strobe. They stay on the outputs until the next command is accepted. Words are stored high byte first, at the lower address. The saved instruction byte is never read back.

Top module: `trap_ctx_seq`

## Requirements
- R1: After reset, `busy`, `done`, `memWe` and `memRe` are all 0.
- R2: On entry, the frame base T is the big-endian word at VEC_SYS_SP (default FFFA, high byte there, low byte at FFFB). The new PC is the big-endian word at VEC_HANDLER (default FFFE/FFFF), read after all frame writes.
- R3: On entry, exactly 10 bytes are written, one per cycle, in this order: instruction byte at T-1; SP high at T-3 and low at T-2; PC high at T-5 and low at T-4; X high at T-7 and low at T-6; A high at T-9 and low at T-8; last, the flags byte {4'b0000, N, Z, V, C} (N in bit 3, C in bit 0) at T-10. The SP written is the value presented at `start`.
- R4: On entry completion, `spOut` = T-10 and `pcOut` = the handler word. `aOut`, `xOut` and `nzvcOut` equal the values presented at `start`.
- R5: On return from base S = `spIn`, `nzvcOut` = bits 3..0 of the byte at S, `aOut` = word at S+1, `xOut` = word at S+3, `pcOut` = word at S+5 and `spOut` = word at S+7. The upper nibble of the flags byte is ignored, and no memory write occurs during a return.
- R6: An entry followed by a return from the resulting `spOut` reproduces the original A, X, PC, NZVC and SP.
- R7: `done` is a single-cycle pulse. It rises 14 cycles after the clock edge that accepts an entry and 9 cycles after one that accepts a return. `busy` is 1 from the cycle after acceptance through the `done` cycle, then drops.
- R8: A `start` raised while `busy` is 1 is ignored: the running operation's writes, results and timing are unchanged, and no second `done` follows.
- R9: All frame address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, accepted when idle |
| startKind | input | 1 | 0 = trap entry, 1 = return from trap |
| instSpec | input | 8 | Instruction-specifier byte to save |
| spIn | input | 16 | Current stack pointer |
| pcIn | input | 16 | Current program counter |
| xIn | input | 16 | Current index register |
| aIn | input | 16 | Current accumulator |
| nzvcIn | input | 4 | Current flags, N in bit 3, C in bit 0 |
| memAddr | output | 16 | Byte address |
| memWe | output | 1 | Byte write strobe |
| memWdata | output | 8 | Byte write data |
| memRe | output | 1 | Byte read strobe |
| memRdata | input | 8 | Read data, valid in the same cycle as the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| spOut | output | 16 | New stack pointer |
| pcOut | output | 16 | New program counter |
| xOut | output | 16 | New index register |
| aOut | output | 16 | New accumulator |
| nzvcOut | output | 4 | New flags |

## Verification
The hardest situation to reach from the ports is a second `start` arriving partway through a running sequence. It is made harder when that second request names the opposite kind of operation, which would corrupt the frame if it were taken. The bench raises `start` again with the other kind at a chosen cycle inside entry and return sequences, then checks the full write log, the results and the latency. Address wrap is reached by handing a return a stack pointer a few bytes below FFFF, so that the frame straddles zero. The round trip feeds the entry's new stack pointer straight into a return over the frame the block itself wrote.

// File: rtl/trap_ctx_pkg.sv
package trap_ctx_pkg;

  localparam int ENTRY_STEPS  = 14;
  localparam int RETURN_STEPS = 9;
  localparam int STEP_W       = $clog2(ENTRY_STEPS);

  typedef enum logic [1:0] {BASE_ABS, BASE_TMP, BASE_STK} baseSel_e;

  typedef enum logic [3:0] {
    WR_INST, WR_SPH, WR_SPL, WR_PCH, WR_PCL,
    WR_XH, WR_XL, WR_AH, WR_AL, WR_FLG
  } wrSel_e;

  typedef enum logic [3:0] {
    LD_NONE, LD_TH, LD_TL, LD_PCH, LD_PCL, LD_AH, LD_AL,
    LD_XH, LD_XL, LD_SPH, LD_SPL, LD_FLG
  } ldSel_e;

  typedef struct packed {
    logic        capture;
    logic        setSp;
    logic        memRe;
    logic        memWe;
    baseSel_e    baseSel;
    logic [15:0] offset;
    wrSel_e      wrSel;
    ldSel_e      ldSel;
  } dpCtl_t;

endpackage

// File: rtl/trap_ctx_ctrl.sv
module trap_ctx_ctrl
  import trap_ctx_pkg::*;
#(
  parameter logic [15:0] VEC_SYS_SP  = 16'hFFFA,
  parameter logic [15:0] VEC_HANDLER = 16'hFFFE
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   startKind,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  localparam logic [STEP_W-1:0] LAST_ENTRY  = STEP_W'(ENTRY_STEPS - 1);
  localparam logic [STEP_W-1:0] LAST_RETURN = STEP_W'(RETURN_STEPS - 1);

  state_e            state;
  logic [STEP_W-1:0] step;
  logic              isRet;
  logic              accept;
  logic              lastStep;

  assign accept   = start && (state == S_IDLE);
  assign lastStep = (step == (isRet ? LAST_RETURN : LAST_ENTRY));
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= '0;
      isRet <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state <= S_RUN;
          step  <= '0;
          isRet <= startKind;
        end
        S_RUN: begin
          if (lastStep) state <= S_FIN;
          else          step  <= step + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.capture = accept;
    if (state == S_RUN) begin
      if (isRet) begin
        ctl.memRe   = 1'b1;
        ctl.baseSel = BASE_STK;
        ctl.offset  = 16'(step);
        case (step)
          4'd0:    ctl.ldSel = LD_FLG;
          4'd1:    ctl.ldSel = LD_AH;
          4'd2:    ctl.ldSel = LD_AL;
          4'd3:    ctl.ldSel = LD_XH;
          4'd4:    ctl.ldSel = LD_XL;
          4'd5:    ctl.ldSel = LD_PCH;
          4'd6:    ctl.ldSel = LD_PCL;
          4'd7:    ctl.ldSel = LD_SPH;
          default: ctl.ldSel = LD_SPL;
        endcase
      end else begin
        ctl.memWe   = (step >= 4'd2) && (step <= 4'd11);
        ctl.memRe   = !ctl.memWe;
        ctl.baseSel = ctl.memWe ? BASE_TMP : BASE_ABS;
        case (step)
          4'd0:  begin ctl.offset = VEC_SYS_SP;          ctl.ldSel = LD_TH;  end
          4'd1:  begin ctl.offset = VEC_SYS_SP + 16'd1;  ctl.ldSel = LD_TL;  end
          4'd2:  begin ctl.offset = -16'sd1;  ctl.wrSel = WR_INST; ctl.setSp = 1'b1; end
          4'd3:  begin ctl.offset = -16'sd3;  ctl.wrSel = WR_SPH; end
          4'd4:  begin ctl.offset = -16'sd2;  ctl.wrSel = WR_SPL; end
          4'd5:  begin ctl.offset = -16'sd5;  ctl.wrSel = WR_PCH; end
          4'd6:  begin ctl.offset = -16'sd4;  ctl.wrSel = WR_PCL; end
          4'd7:  begin ctl.offset = -16'sd7;  ctl.wrSel = WR_XH;  end
          4'd8:  begin ctl.offset = -16'sd6;  ctl.wrSel = WR_XL;  end
          4'd9:  begin ctl.offset = -16'sd9;  ctl.wrSel = WR_AH;  end
          4'd10: begin ctl.offset = -16'sd8;  ctl.wrSel = WR_AL;  end
          4'd11: begin ctl.offset = -16'sd10; ctl.wrSel = WR_FLG; end
          4'd12: begin ctl.offset = VEC_HANDLER;         ctl.ldSel = LD_PCH; end
          default: begin ctl.offset = VEC_HANDLER + 16'd1; ctl.ldSel = LD_PCL; end
        endcase
      end
    end
  end

endmodule

// File: rtl/trap_ctx_dp.sv
module trap_ctx_dp
  import trap_ctx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [7:0]  instSpec,
  input  logic [15:0] spIn,
  input  logic [15:0] pcIn,
  input  logic [15:0] xIn,
  input  logic [15:0] aIn,
  input  logic [3:0]  nzvcIn,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic [7:0]  memWdata,
  output logic        memRe,
  output logic [15:0] spOut,
  output logic [15:0] pcOut,
  output logic [15:0] xOut,
  output logic [15:0] aOut,
  output logic [3:0]  nzvcOut
);

  localparam logic [15:0] FRAME_BYTES = 16'd10;

  logic [7:0]  instCap;
  logic [15:0] spCap;
  logic [15:0] tmp;
  logic [15:0] base;

  always_comb begin
    case (ctl.baseSel)
      BASE_TMP: base = tmp;
      BASE_STK: base = spCap;
      default:  base = 16'h0000;
    endcase
  end

  assign memAddr = base + ctl.offset;
  assign memWe   = ctl.memWe;
  assign memRe   = ctl.memRe;

  always_comb begin
    case (ctl.wrSel)
      WR_INST: memWdata = instCap;
      WR_SPH:  memWdata = spCap[15:8];
      WR_SPL:  memWdata = spCap[7:0];
      WR_PCH:  memWdata = pcOut[15:8];
      WR_PCL:  memWdata = pcOut[7:0];
      WR_XH:   memWdata = xOut[15:8];
      WR_XL:   memWdata = xOut[7:0];
      WR_AH:   memWdata = aOut[15:8];
      WR_AL:   memWdata = aOut[7:0];
      default: memWdata = {4'b0000, nzvcOut};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instCap <= '0;
      spCap   <= '0;
      tmp     <= '0;
      spOut   <= '0;
      pcOut   <= '0;
      xOut    <= '0;
      aOut    <= '0;
      nzvcOut <= '0;
    end else if (ctl.capture) begin
      instCap <= instSpec;
      spCap   <= spIn;
      spOut   <= spIn;
      pcOut   <= pcIn;
      xOut    <= xIn;
      aOut    <= aIn;
      nzvcOut <= nzvcIn;
    end else begin
      if (ctl.setSp) spOut <= tmp - FRAME_BYTES;
      if (ctl.memRe) begin
        case (ctl.ldSel)
          LD_TH:   tmp[15:8]   <= memRdata;
          LD_TL:   tmp[7:0]    <= memRdata;
          LD_PCH:  pcOut[15:8] <= memRdata;
          LD_PCL:  pcOut[7:0]  <= memRdata;
          LD_AH:   aOut[15:8]  <= memRdata;
          LD_AL:   aOut[7:0]   <= memRdata;
          LD_XH:   xOut[15:8]  <= memRdata;
          LD_XL:   xOut[7:0]   <= memRdata;
          LD_SPH:  spOut[15:8] <= memRdata;
          LD_SPL:  spOut[7:0]  <= memRdata;
          LD_FLG:  nzvcOut     <= memRdata[3:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/trap_ctx_seq.sv
module trap_ctx_seq
  import trap_ctx_pkg::*;
#(
  parameter logic [15:0] VEC_SYS_SP  = 16'hFFFA,
  parameter logic [15:0] VEC_HANDLER = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        startKind,
  input  logic [7:0]  instSpec,
  input  logic [15:0] spIn,
  input  logic [15:0] pcIn,
  input  logic [15:0] xIn,
  input  logic [15:0] aIn,
  input  logic [3:0]  nzvcIn,
  output logic [15:0] memAddr,
  output logic        memWe,
  output logic [7:0]  memWdata,
  output logic        memRe,
  input  logic [7:0]  memRdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] spOut,
  output logic [15:0] pcOut,
  output logic [15:0] xOut,
  output logic [15:0] aOut,
  output logic [3:0]  nzvcOut
);

  dpCtl_t ctl;

  trap_ctx_ctrl #(.VEC_SYS_SP(VEC_SYS_SP), .VEC_HANDLER(VEC_HANDLER)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .startKind(startKind),
    .ctl(ctl), .busy(busy), .done(done)
  );

  trap_ctx_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .instSpec(instSpec), .spIn(spIn), .pcIn(pcIn), .xIn(xIn), .aIn(aIn),
    .nzvcIn(nzvcIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata), .memRe(memRe),
    .spOut(spOut), .pcOut(pcOut), .xOut(xOut), .aOut(aOut), .nzvcOut(nzvcOut)
  );

endmodule

// File: rtl/trap_ctx_chk.sv
module trap_ctx_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic startKind,
  input logic memWe,
  input logic memRe,
  input logic busy,
  input logic done
);

  logic       retMode;
  logic [4:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retMode <= 1'b0;
      cnt     <= '0;
    end else if (start && !busy) begin
      retMode <= startKind;
      cnt     <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe));

  // R3
  single_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, memRe}));

  // R5
  ret_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && retMode) |-> !memWe);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && (cnt == (retMode ? 5'd9 : 5'd14))));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);

endmodule

bind trap_ctx_seq trap_ctx_chk uChk (
  .clk(clk), .rstN(rstN), .start(start), .startKind(startKind),
  .memWe(memWe), .memRe(memRe), .busy(busy), .done(done)
);

// File: tb/sim_trap_ctx_seq.sv
`timescale 1ns/1ps
module sim_trap_ctx_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        startKind = 1'b0;
  logic [7:0]  instSpec = '0;
  logic [15:0] spIn = '0, pcIn = '0, xIn = '0, aIn = '0;
  logic [3:0]  nzvcIn = '0;
  logic [15:0] memAddr;
  logic        memWe, memRe;
  logic [7:0]  memWdata, memRdata;
  logic        busy, done;
  logic [15:0] spOut, pcOut, xOut, aOut;
  logic [3:0]  nzvcOut;

  always #2 clk = ~clk;

  trap_ctx_seq u0 (.*);

  logic [7:0]  mem [0:255];
  logic [15:0] wAddr [0:15];
  logic [7:0]  wData [0:15];
  int          wCnt = 0;
  int          nChk = 0;
  int          nFail = 0;
  bit          finished = 0;

  assign memRdata = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[7:0]] <= memWdata;
      wAddr[wCnt % 16]  <= memAddr;
      wData[wCnt % 16]  <= memWdata;
      wCnt              <= wCnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putWord(input logic [15:0] ad, input logic [15:0] w);
    mem[ad[7:0]]         = w[15:8];
    mem[8'(ad[7:0] + 1)] = w[7:0];
  endtask

  task automatic runOp(input logic kind, input int pokeAt, output int lat);
    @(negedge clk);
    startKind = kind;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk("R7 busy after accept", busy, 1);
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (lat == pokeAt) begin
        start = 1'b1;
        startKind = ~kind;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk("R7 done single pulse", done, 0);
    chk("R7 busy clears after done", busy, 0);
    repeat (3) @(negedge clk);
    chk("R8 no second done", {busy, done}, 0);
  endtask

  task automatic testEntry(input string nm, input logic [15:0] t, input logic [7:0] ins,
                           input logic [15:0] sp, input logic [15:0] pc, input logic [15:0] x,
                           input logic [15:0] a, input logic [3:0] f, input logic [15:0] h,
                           input int poke);
    logic [15:0] eA [0:9];
    logic [7:0]  eD [0:9];
    int lat, base;
    putWord(16'hFFFA, t);
    putWord(16'hFFFE, h);
    instSpec = ins; spIn = sp; pcIn = pc; xIn = x; aIn = a; nzvcIn = f;
    eA[0] = t - 16'd1;  eD[0] = ins;
    eA[1] = t - 16'd3;  eD[1] = sp[15:8];
    eA[2] = t - 16'd2;  eD[2] = sp[7:0];
    eA[3] = t - 16'd5;  eD[3] = pc[15:8];
    eA[4] = t - 16'd4;  eD[4] = pc[7:0];
    eA[5] = t - 16'd7;  eD[5] = x[15:8];
    eA[6] = t - 16'd6;  eD[6] = x[7:0];
    eA[7] = t - 16'd9;  eD[7] = a[15:8];
    eA[8] = t - 16'd8;  eD[8] = a[7:0];
    eA[9] = t - 16'd10; eD[9] = {4'b0000, f};
    base = wCnt;
    runOp(1'b0, poke, lat);
    chk({"R7 entry latency ", nm}, lat, 14);
    chk({"R3 entry write count ", nm}, wCnt - base, 10);
    for (int i = 0; i < 10; i++) begin
      chk({"R3 frame address ", nm}, wAddr[(base + i) % 16], eA[i]);
      chk({"R3 frame byte ", nm}, wData[(base + i) % 16], eD[i]);
    end
    chk({"R4 spOut T-10 ", nm}, spOut, t - 16'd10);
    chk({"R2 pcOut handler ", nm}, pcOut, h);
    chk({"R4 aOut kept ", nm}, aOut, a);
    chk({"R4 xOut kept ", nm}, xOut, x);
    chk({"R4 nzvcOut kept ", nm}, nzvcOut, f);
  endtask

  task automatic testReturn(input string nm, input logic [15:0] s, input logic [7:0] fb,
                            input logic [15:0] a, input logic [15:0] x, input logic [15:0] pc,
                            input logic [15:0] nsp, input int poke);
    int lat, base;
    mem[s[7:0]] = fb;
    putWord(s + 16'd1, a);
    putWord(s + 16'd3, x);
    putWord(s + 16'd5, pc);
    putWord(s + 16'd7, nsp);
    spIn = s; aIn = 16'hDEAD; xIn = 16'hBEEF; pcIn = 16'h0BAD; nzvcIn = ~fb[3:0];
    instSpec = 8'h5A;
    base = wCnt;
    runOp(1'b1, poke, lat);
    chk({"R7 return latency ", nm}, lat, 9);
    chk({"R5 return writes nothing ", nm}, wCnt - base, 0);
    chk({"R5 nzvc from low nibble ", nm}, nzvcOut, fb[3:0]);
    chk({"R5 aOut ", nm}, aOut, a);
    chk({"R5 xOut ", nm}, xOut, x);
    chk({"R5 pcOut ", nm}, pcOut, pc);
    chk({"R5 spOut ", nm}, spOut, nsp);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 busy at reset", busy, 0);
    chk("R1 done at reset", done, 0);
    chk("R1 memWe at reset", memWe, 0);
    chk("R1 memRe at reset", memRe, 0);
  endtask

  task automatic testRoundTrip();
    int lat;
    logic [15:0] entSp;
    testEntry("roundtrip", 16'h20C0, 8'h3C, 16'h1F00, 16'h0456, 16'h7788, 16'h99AA, 4'b0110,
              16'h8000, 0);
    entSp = spOut;
    spIn = entSp; aIn = 16'h0; xIn = 16'h0; pcIn = 16'h0; nzvcIn = 4'h0;
    runOp(1'b1, 0, lat);
    chk("R6 roundtrip A", aOut, 16'h99AA);
    chk("R6 roundtrip X", xOut, 16'h7788);
    chk("R6 roundtrip PC", pcOut, 16'h0456);
    chk("R6 roundtrip NZVC", nzvcOut, 4'b0110);
    chk("R6 roundtrip SP", spOut, 16'h1F00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testEntry("basic", 16'h4080, 8'hC1, 16'h0FF2, 16'h1234, 16'h5678, 16'h9ABC, 4'b1010,
              16'hFC4F, 0);
    testEntry("allflags", 16'h1234, 8'hFF, 16'hFFFF, 16'h0001, 16'h8000, 16'h7FFF, 4'b1111,
              16'h0102, 0);
    testEntry("R8 poke", 16'h6050, 8'h2E, 16'hABCD, 16'hEF01, 16'h2345, 16'h6789, 4'b0001,
              16'h4321, 5);
    testReturn("basic", 16'h3040, 8'hF9, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 0);
    testReturn("R9 wrap", 16'hFFFB, 8'h04, 16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h0718, 0);
    testReturn("R8 poke", 16'h5010, 8'h60, 16'h0F0F, 16'hF0F0, 16'h1357, 16'h2468, 3);
    testRoundTrip();
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule